// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and the functional units of a wide-issue core. It accepts a fetch packet of eight 32-bit instruction slots, plus a small unit-select field for each slot. It then splits the packet into execute packets. Bit 0 of every instruction is a chaining bit. Slots are taken in ascending order. While an instruction has its chaining bit set, the slot after it joins the same execute packet. A clear bit closes the group, and the following slot starts a new one in the next cycle. The last slot always closes its group, so an execute packet never crosses into the next fetch packet. One fetch packet therefore produces between one and eight execute packets, one per cycle.

Each execute packet is routed to eight functional-unit outputs. These are two units of each of four kinds. The unit index takes the kind as its upper bits and the side as its lowest bit. If two members of a packet select the same unit, the block raises a conflict flag for that cycle and issues none of that packet's members. The packet's slots are still consumed. The block holds the fetch packet and a slot pointer. It withholds its ready signal until the cycle that issues the final execute packet of the held packet. A new packet can therefore be taken in that same cycle. A start index and a slot count describe every issued execute packet.

Top module: `dp_dispatch`

## Requirements
- R1: While reset is applied and after it, with no packet offered, fp_ready is 1 and ep_valid, conflict and every unit_valid bit are 0.
- R2: A fetch packet is taken on a clock edge where fp_valid and fp_ready are both 1. While a packet is held and its final execute packet is not issuing, fp_ready is 0. A packet offered in such a cycle is ignored and the held packet keeps issuing unchanged.
- R3: Instruction j sits at fp_data[32j+31:32j], and its bit 0 is the chaining bit. An execute packet starts at the slot pointer and extends through each following slot while the previous member's chaining bit is 1. ep_count gives the number of members.
- R4: The chaining bit of slot 7 is treated as 0. The group containing slot 7 ends there, and the next execute packet comes from the next fetch packet with ep_start 0.
- R5: While a packet is held, ep_valid is 1 every cycle and exactly one execute packet issues. The first execute packet has ep_start 0. Each later one starts at the previous ep_start plus ep_count.
- R6: Slot j selects unit fp_unit[3j+2:3j]. For a packet without a conflict, unit_valid[u] is 1 exactly for the units named by its members, and unit_word[32u+31:32u] carries the member instruction word.
- R7: If two members of one execute packet name the same unit, conflict is 1 in that cycle. All unit_valid bits are then 0 and all unit_word bits are 0, and the pointer still advances past the packet.
- R8: fp_ready is 1 in the cycle that issues the final execute packet of the held packet. A packet offered then is taken with no idle cycle, and its first execute packet issues in the next cycle.
- R9: A unit not named by the issuing execute packet, or any unit while no packet is held, has unit_valid 0 and a zero unit_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Fetch packet can be taken this cycle |
| fp_data | input | 256 | Eight instruction slots, slot 0 in the low word |
| fp_unit | input | 24 | Three-bit unit select per slot, slot 0 in the low bits |
| unit_valid | output | 8 | Per-unit issue strobe |
| unit_word | output | 256 | Per-unit instruction word, unit 0 in the low word |
| conflict | output | 1 | Issuing execute packet names one unit twice |
| ep_valid | output | 1 | An execute packet issues this cycle |
| ep_start | output | 3 | First slot of the issuing execute packet |
| ep_count | output | 4 | Number of slots in the issuing execute packet |

## Verification
The bench covers several groupings: a packet with all chaining bits clear, which a wrong scan would merge into fewer groups, and a fully chained packet, which a scan that honoured the last chaining bit would stretch or split. It also covers a chained last slot after an unchained slot 6, where a wrong design would carry the group into the next fetch packet. A duplicate-unit group checks that conflict rises, and a design that only flagged it would still strobe units. Packets offered back to back probe the ready handover. A late ready would show as an idle cycle, and an early ready would overwrite a packet still issuing. Random chaining patterns and unit selects mixed with idle gaps fill in the rest.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // default geometry of the dispatcher
  localparam int DP_SLOTS = 8;
  localparam int DP_UNITS = 8;
  localparam int DP_IW    = 32;

  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_BUSY = 1'b1
  } hold_state_e;
endpackage

// File: rtl/dp_group_scan.sv
module dp_group_scan #(
  parameter  int NSLOT = 8,
  localparam int PW    = $clog2(NSLOT),
  localparam int CW    = $clog2(NSLOT + 1)
) (
  input  logic             active,
  input  logic [PW-1:0]    ptr,
  input  logic [NSLOT-1:0] chain,
  output logic [NSLOT-1:0] mask,
  output logic [CW-1:0]    count,
  output logic             is_last,
  output logic [PW-1:0]    next_ptr
);
  logic open;

  // walk upward from the pointer; a clear chaining bit closes the group,
  // and the loop bound closes it at the top slot whatever its bit says
  always_comb begin
    mask = '0;
    open = active;
    for (int j = 0; j < NSLOT; j++) begin
      if (open && (PW'(j) >= ptr)) begin
        mask[j] = 1'b1;
        if (!chain[j]) open = 1'b0;
      end
    end
  end

  always_comb begin
    count = '0;
    for (int j = 0; j < NSLOT; j++) begin
      count = count + CW'(mask[j]);
    end
  end

  assign is_last  = mask[NSLOT-1];
  assign next_ptr = ptr + PW'(count);
endmodule

// File: rtl/dp_unit_router.sv
module dp_unit_router #(
  parameter  int NSLOT = 8,
  parameter  int NUNIT = 8,
  parameter  int IW    = 32,
  localparam int UW    = $clog2(NUNIT)
) (
  input  logic [NSLOT-1:0]    mask,
  input  logic [NSLOT*IW-1:0] words,
  input  logic [NSLOT*UW-1:0] units,
  output logic [NUNIT-1:0]    unit_valid,
  output logic [NUNIT*IW-1:0] unit_word,
  output logic                conflict
);
  logic [NUNIT-1:0] dup;
  logic [NUNIT-1:0] any_hit;

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic [NSLOT-1:0] hits;
    logic [IW-1:0]    word;

    always_comb begin
      hits = '0;
      word = '0;
      for (int j = 0; j < NSLOT; j++) begin
        if (mask[j] && (units[j*UW +: UW] == UW'(u))) begin
          hits[j] = 1'b1;
          word    = word | words[j*IW +: IW];
        end
      end
    end

    assign dup[u]     = ($countones(hits) > 1);
    assign any_hit[u] = |hits;
    assign unit_word[u*IW +: IW] = conflict ? '0 : word;
  end

  assign conflict   = |dup;
  assign unit_valid = conflict ? '0 : any_hit;
endmodule

// File: rtl/dp_fetch_hold.sv
module dp_fetch_hold
  import dp_pkg::*;
#(
  parameter  int NSLOT = 8,
  parameter  int IW    = 32,
  parameter  int UW    = 3,
  localparam int PW    = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_q,
  input  logic                fp_valid,
  input  logic [NSLOT*IW-1:0] fp_data,
  input  logic [NSLOT*UW-1:0] fp_unit,
  input  logic                issue_last,
  input  logic [PW-1:0]       next_ptr,
  output logic                fp_ready,
  output logic                busy,
  output logic [PW-1:0]       ptr,
  output logic [NSLOT*IW-1:0] held_data,
  output logic [NSLOT*UW-1:0] held_unit
);
  hold_state_e state_q, state_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          accept;
  logic          ptr_en;
  logic          load_en;

  assign busy     = (state_q == HOLD_BUSY);
  assign fp_ready = !busy || issue_last;
  assign accept   = fp_valid && fp_ready;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    load_en = 1'b0;
    if (busy) begin
      ptr_en = 1'b1;
      ptr_d  = next_ptr;
      if (issue_last) state_d = HOLD_IDLE;
    end
    if (accept) begin
      load_en = 1'b1;
      ptr_en  = 1'b1;
      ptr_d   = '0;
      state_d = HOLD_BUSY;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= HOLD_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  // payload registers carry no reset; they are read only while busy
  always_ff @(posedge clk) begin
    if (load_en) begin
      held_data <= fp_data;
      held_unit <= fp_unit;
    end
  end

  assign ptr = ptr_q;

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && !fp_ready) |=> ($stable(held_data) && $stable(held_unit))) // R2
    else $error("held packet changed while not ready");
endmodule

// File: rtl/dp_dispatch.sv
module dp_dispatch
  import dp_pkg::*;
#(
  parameter  int NSLOT = DP_SLOTS,
  parameter  int NUNIT = DP_UNITS,
  parameter  int IW    = DP_IW,
  localparam int UW    = $clog2(NUNIT),
  localparam int PW    = $clog2(NSLOT),
  localparam int CW    = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fp_valid,
  output logic                fp_ready,
  input  logic [NSLOT*IW-1:0] fp_data,
  input  logic [NSLOT*UW-1:0] fp_unit,
  output logic [NUNIT-1:0]    unit_valid,
  output logic [NUNIT*IW-1:0] unit_word,
  output logic                conflict,
  output logic                ep_valid,
  output logic [PW-1:0]       ep_start,
  output logic [CW-1:0]       ep_count
);
  logic                rst_meta, rst_q;
  logic                busy;
  logic [PW-1:0]       ptr;
  logic [PW-1:0]       next_ptr;
  logic [NSLOT*IW-1:0] held_data;
  logic [NSLOT*UW-1:0] held_unit;
  logic [NSLOT-1:0]    chain;
  logic [NSLOT-1:0]    mask;
  logic [CW-1:0]       count;
  logic                is_last;

  // reset asserts at once and leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  for (genvar j = 0; j < NSLOT; j++) begin : g_chain
    assign chain[j] = held_data[j*IW];
  end

  dp_fetch_hold #(.NSLOT(NSLOT), .IW(IW), .UW(UW)) u_hold (
    .clk        (clk),
    .rst_q      (rst_q),
    .fp_valid   (fp_valid),
    .fp_data    (fp_data),
    .fp_unit    (fp_unit),
    .issue_last (is_last),
    .next_ptr   (next_ptr),
    .fp_ready   (fp_ready),
    .busy       (busy),
    .ptr        (ptr),
    .held_data  (held_data),
    .held_unit  (held_unit)
  );

  dp_group_scan #(.NSLOT(NSLOT)) u_scan (
    .active   (busy),
    .ptr      (ptr),
    .chain    (chain),
    .mask     (mask),
    .count    (count),
    .is_last  (is_last),
    .next_ptr (next_ptr)
  );

  dp_unit_router #(.NSLOT(NSLOT), .NUNIT(NUNIT), .IW(IW)) u_route (
    .mask       (mask),
    .words      (held_data),
    .units      (held_unit),
    .unit_valid (unit_valid),
    .unit_word  (unit_word),
    .conflict   (conflict)
  );

  assign ep_valid = busy;
  assign ep_start = ptr;
  assign ep_count = count;

  AST_ISSUE_SPAN: assert property (@(posedge clk) disable iff (!rst_q)
    ep_valid |-> (ep_count != '0 && (CW'(ep_start) + ep_count) <= CW'(NSLOT))) // R3
    else $error("execute packet span out of range");

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_q)
    (ep_valid && !fp_ready) |=> (ep_valid && CW'(ep_start) == CW'($past(ep_start)) + $past(ep_count))) // R5
    else $error("execute packets not contiguous");

  AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (fp_valid && fp_ready) |=> (ep_valid && ep_start == '0)) // R8
    else $error("accepted packet did not start at slot 0");

  AST_UNIT_COUNT: assert property (@(posedge clk) disable iff (!rst_q)
    (ep_valid && !conflict) |-> ($countones(unit_valid) == int'(ep_count))) // R6
    else $error("unit strobes disagree with packet size");

  AST_CONFLICT_SILENT: assert property (@(posedge clk) disable iff (!rst_q)
    conflict |-> (unit_valid == '0 && ep_valid)) // R7
    else $error("conflicting packet issued units");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !ep_valid |-> (unit_valid == '0 && !conflict && fp_ready)) // R9
    else $error("units strobed with nothing held");
endmodule

// File: tb/dp_dispatch_bench.sv
module dp_dispatch_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         fp_valid;
  logic         fp_ready;
  logic [255:0] fp_data;
  logic [23:0]  fp_unit;
  logic [7:0]   unit_valid;
  logic [255:0] unit_word;
  logic         conflict;
  logic         ep_valid;
  logic [2:0]   ep_start;
  logic [3:0]   ep_count;

  always #10 clk = ~clk;

  dp_dispatch u_dp_dispatch (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_data(fp_data), .fp_unit(fp_unit), .unit_valid(unit_valid),
    .unit_word(unit_word), .conflict(conflict), .ep_valid(ep_valid),
    .ep_start(ep_start), .ep_count(ep_count)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference state
  bit          m_busy = 1'b0;
  int          m_ptr  = 0;
  logic [31:0] m_word [8];
  logic [2:0]  m_unit [8];
  int          gap    = 0;

  logic [255:0] q_data [$];
  logic [23:0]  q_unit [$];
  int           q_gap  [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] seq_units();
    logic [23:0] u;
    for (int j = 0; j < 8; j++) u[j*3 +: 3] = 3'(j);
    return u;
  endfunction

  task automatic add_pkt(input logic [7:0] pb, input logic [23:0] un, input int gp);
    logic [255:0] d;
    for (int j = 0; j < 8; j++) begin
      logic [31:0] r;
      r = $urandom;
      r[0] = pb[j];
      d[j*32 +: 32] = r;
    end
    q_data.push_back(d);
    q_unit.push_back(un);
    q_gap.push_back(gp);
  endtask

  // compare against the model for the current cycle, then drive and advance
  task automatic step();
    int       cnt;
    bit       last;
    bit       conf;
    bit       e_ready;
    logic [7:0]   mask;
    logic [7:0]   e_uv;
    logic [255:0] e_uw;
    @(negedge clk);
    cnt = 0; last = 1'b0; conf = 1'b0; mask = '0; e_uv = '0; e_uw = '0;
    if (m_busy) begin
      for (int j = m_ptr; j < 8; j++) begin
        mask[j] = 1'b1;
        cnt++;
        if (j == 7) last = 1'b1;
        if (!m_word[j][0]) break;
      end
    end
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++)
        if (mask[a] && mask[b] && m_unit[a] == m_unit[b]) conf = 1'b1;
    if (!conf)
      for (int j = 0; j < 8; j++)
        if (mask[j]) begin
          e_uv[m_unit[j]] = 1'b1;
          e_uw[m_unit[j]*32 +: 32] = m_word[j];
        end
    e_ready = !m_busy || last;

    chk(fp_ready == e_ready, last ? "R8" : "R2", "fp_ready", 256'(fp_ready), 256'(e_ready));
    chk(ep_valid == m_busy, "R5", "ep_valid", 256'(ep_valid), 256'(m_busy));
    if (m_busy) begin
      chk(int'(ep_start) == m_ptr, "R5", "ep_start", 256'(ep_start), 256'(m_ptr));
      chk(int'(ep_count) == cnt, (last && m_word[7][0]) ? "R4" : "R3", "ep_count",
          256'(ep_count), 256'(cnt));
    end
    chk(conflict == conf, "R7", "conflict", 256'(conflict), 256'(conf));
    chk(unit_valid == e_uv, m_busy ? "R6" : "R9", "unit_valid", 256'(unit_valid), 256'(e_uv));
    chk(unit_word == e_uw, conf ? "R7" : "R6", "unit_word", unit_word, e_uw);

    // drive inputs for the next edge
    if (gap > 0) begin
      fp_valid = 1'b0;
      gap--;
    end else if (q_data.size() > 0) begin
      fp_valid = 1'b1;
      fp_data  = q_data[0];
      fp_unit  = q_unit[0];
    end else begin
      fp_valid = 1'b0;
    end
    if (!fp_valid) begin
      for (int j = 0; j < 8; j++) fp_data[j*32 +: 32] = $urandom;
      fp_unit = 24'($urandom);
    end

    // advance the model through that edge
    if (m_busy) begin
      m_ptr += cnt;
      if (last) m_busy = 1'b0;
    end
    if (fp_valid && e_ready) begin
      for (int j = 0; j < 8; j++) begin
        m_word[j] = fp_data[j*32 +: 32];
        m_unit[j] = fp_unit[j*3 +: 3];
      end
      m_busy = 1'b1;
      m_ptr  = 0;
      void'(q_data.pop_front());
      void'(q_unit.pop_front());
      void'(q_gap.pop_front());
      gap = (q_gap.size() > 0) ? q_gap[0] : 0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] un;
    rst_n    = 1'b0;
    fp_valid = 1'b0;
    fp_data  = '0;
    fp_unit  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fp_ready == 1'b1, "R1", "fp_ready", 256'(fp_ready), 256'(1));
    chk(ep_valid == 1'b0, "R1", "ep_valid", 256'(ep_valid), 256'(0));
    chk(unit_valid == '0, "R1", "unit_valid", 256'(unit_valid), 256'(0));
    chk(conflict == 1'b0, "R1", "conflict", 256'(conflict), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(fp_ready == 1'b1 && ep_valid == 1'b0, "R1", "after release",
        256'({fp_ready, ep_valid}), 256'(2'b10));

    // directed groupings
    add_pkt(8'h00, seq_units(), 0);           // eight single groups (R5)
    add_pkt(8'hFF, seq_units(), 0);           // one full group, slot 7 bit ignored (R4)
    add_pkt(8'b0101_0011, seq_units(), 1);    // mixed lengths (R3)
    un = seq_units();
    un[5:3] = 3'd0;                           // slots 0 and 1 both pick unit 0 (R7)
    add_pkt(8'b0000_0001, un, 0);
    add_pkt(8'b1011_1111, seq_units(), 0);    // slot 7 alone with its bit set (R4)
    add_pkt(8'h00, seq_units(), 0);           // back-to-back handover (R8)
    add_pkt(8'hFF, {8{3'd3}}, 2);             // full group all on one unit (R7)
    for (int k = 0; k < 150; k++) begin
      logic [7:0] pb;
      pb = 8'($urandom | $urandom);
      if (k % 3 == 0) un = seq_units();
      else un = 24'($urandom);
      add_pkt(pb, un, int'($urandom % 3));
    end

    while (q_data.size() > 0 || m_busy) step();
    repeat (4) step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule